// File: doc/BRIEF.md
# Remote-Control Key Code Lookup

This block turns a decoded infrared remote frame into a key code. Each frame arrives as a 16-bit user code (which identifies the remote) and an 8-bit scan code (which identifies the button), marked by a one-cycle valid strobe. A small table that is loaded through a write port maps them to key codes. The table is organised as groups: each group carries one user code, a button count, and a list of scan-code/key-code slots. The block first finds the group for the remote, and then searches only the buttons of that group.

The search is sequential and examines one group or one slot per clock. `busy` is high while it runs, and a one-cycle `done` pulse marks new results. The block also counts how many times in a row the same key code has been produced. Software can use this count to tell a held button from a fresh press. Waveform decoding happens upstream and is not part of this block.

Top module: `ir_keymap_lookup`

## Requirements
- R1: After reset, `key_code`, `key_repeat`, `hit`, `miss`, `done` and `busy` are all 0, and every group is empty (stored user code 0).
- R2: A group write whose user code is 0 is dropped. The group keeps its previous user code and button count.
- R3: Groups are scanned from index 0 upward, and only the first group whose stored user code equals the frame's user code is searched. A later group with the same user code is never consulted.
- R4: Inside the selected group, only slots 0 to count-1 are compared, where count is the button count written for that group. A count written above MAX_BUTTONS is stored as MAX_BUTTONS.
- R5: On a scan-code match, `key_code` takes the slot's key code, `hit`=1 and `miss`=0.
- R6: If no group or no slot matches, `key_code` becomes 0 (the no-key value), `key_repeat` becomes 0, `hit`=0 and `miss`=1.
- R7: On a match, `key_repeat` increments if the new key code equals the `key_code` being shown. Otherwise it returns to 0.
- R8: `key_repeat` is 8 bits wide and holds at 255 instead of wrapping.
- R9: Let E0 be the edge that accepts a frame. `done` rises after edge E0+g+s+2 for a hit in group g, slot s. It rises after E0+g+n+2 when group g matches but none of its n buttons match, and after E0+NUM_GROUPS when no group matches. `busy` is high from E0 until `done`.
- R10: A frame strobe that arrives while `busy` is high is ignored. The running search completes with its own codes, and no extra result is produced.
- R11: An incoming user code of 0 never matches any group and produces a miss.
- R12: `done` lasts exactly one cycle. `key_code`, `key_repeat`, `hit` and `miss` change only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe for a decoded frame |
| frame_ucode | input | 16 | User code of the frame |
| frame_scan | input | 8 | Scan code of the frame |
| grp_wr_en | input | 1 | Group header write strobe |
| grp_wr_idx | input | 2 | Group index to write |
| grp_wr_ucode | input | 16 | User code for the group (0 is dropped) |
| grp_wr_count | input | 6 | Number of valid buttons in the group |
| btn_wr_en | input | 1 | Button slot write strobe |
| btn_wr_grp | input | 2 | Group of the slot |
| btn_wr_slot | input | 5 | Slot index within the group |
| btn_wr_scan | input | 8 | Scan code of the slot |
| btn_wr_key | input | 8 | Key code of the slot |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results updated |
| key_code | output | 8 | Last key code, 0 when nothing matched |
| key_repeat | output | 8 | Consecutive repeats of the same key code |
| hit | output | 1 | Last search matched |
| miss | output | 1 | Last search did not match |

## Verification
The bench checks that a duplicated user code in a later group is shadowed by the earlier group. A design that scanned every group would return the later group's key instead of a miss. It also writes stale slots just past a group's button count and writes an over-range count. A design that ignores the count would hit on a stale slot, and one that does not clamp it would read past the group. The bench runs the repeat counter past 255 and then breaks the run with a miss, so it catches a counter that wraps to 0 and one that survives the clear. It also injects frames while a search is running and measures the exact latency of every result. A design that reloaded its codes mid-search, or that skipped or added a group or slot step, would show a wrong key or a wrong cycle count.

// File: rtl/ir_keymap_pkg.sv
package ir_keymap_pkg;

  localparam int UCODE_W = 16;
  localparam int SCAN_W  = 8;
  localparam int KEY_W   = 8;
  localparam int RPT_W   = 8;

  typedef logic [UCODE_W-1:0] ucode_t;
  typedef logic [SCAN_W-1:0]  scan_t;
  typedef logic [KEY_W-1:0]   key_t;
  typedef logic [RPT_W-1:0]   rpt_t;

  localparam key_t KEY_NONE = '0;
  localparam rpt_t RPT_MAX  = '1;

  typedef enum logic [1:0] {
    SRCH_IDLE = 2'd0,
    SRCH_GRP  = 2'd1,
    SRCH_BTN  = 2'd2
  } srch_state_e;

  // A stored user code of zero marks an empty group and never matches.
  function automatic logic f_group_match(ucode_t stored, ucode_t incoming);
    return (stored != '0) && (stored == incoming);
  endfunction

  // Repeat count that follows a match producing key 'nkey'.
  function automatic rpt_t f_next_repeat(key_t shown, key_t nkey, rpt_t cur);
    if (shown != nkey) return '0;
    if (cur == RPT_MAX) return cur;
    return cur + rpt_t'(1);
  endfunction

  // Clamp a requested button count to the slot capacity.
  function automatic int unsigned f_clamp_count(int unsigned req, int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

endpackage

// File: rtl/ikm_group_regs.sv
module ikm_group_regs
  import ir_keymap_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int MAX_BUTTONS = 32,
  localparam int GIW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int CNT_W = $clog2(MAX_BUTTONS + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [GIW-1:0]                   wr_idx,
  input  ucode_t                           wr_ucode,
  input  logic [CNT_W-1:0]                 wr_count,
  output logic [NUM_GROUPS-1:0][UCODE_W-1:0] grp_ucode,
  output logic [NUM_GROUPS-1:0][CNT_W-1:0]   grp_count
);

  logic             wr_accept;
  logic [CNT_W-1:0] wr_count_clamped;

  assign wr_accept        = wr_en && (wr_ucode != '0);
  assign wr_count_clamped = CNT_W'(f_clamp_count(int'(wr_count), MAX_BUTTONS));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        grp_ucode[g] <= '0;
        grp_count[g] <= '0;
      end else if (wr_accept && (wr_idx == GIW'(g))) begin
        grp_ucode[g] <= wr_ucode;
        grp_count[g] <= wr_count_clamped;
      end
    end
  end

endmodule

// File: rtl/ikm_button_store.sv
module ikm_button_store
  import ir_keymap_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int MAX_BUTTONS = 32,
  localparam int GIW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int SIW = (MAX_BUTTONS > 1) ? $clog2(MAX_BUTTONS) : 1,
  localparam int DEPTH = NUM_GROUPS * MAX_BUTTONS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [GIW-1:0] wr_grp,
  input  logic [SIW-1:0] wr_slot,
  input  scan_t          wr_scan,
  input  key_t           wr_key,
  input  logic [GIW-1:0] rd_grp,
  input  logic [SIW-1:0] rd_slot,
  output scan_t          rd_scan,
  output key_t           rd_key
);

  localparam int AW = $clog2(DEPTH);

  scan_t scan_mem [DEPTH];
  key_t  key_mem  [DEPTH];

  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  function automatic logic [AW-1:0] f_addr(logic [GIW-1:0] g, logic [SIW-1:0] s);
    return AW'(int'(g) * MAX_BUTTONS + int'(s));
  endfunction

  assign wr_addr = f_addr(wr_grp, wr_slot);
  assign rd_addr = f_addr(rd_grp, rd_slot);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        scan_mem[i] <= '0;
        key_mem[i]  <= KEY_NONE;
      end else if (wr_en && (wr_addr == AW'(i))) begin
        scan_mem[i] <= wr_scan;
        key_mem[i]  <= wr_key;
      end
    end
  end

  assign rd_scan = scan_mem[rd_addr];
  assign rd_key  = key_mem[rd_addr];

endmodule

// File: rtl/ikm_search_ctrl.sv
module ikm_search_ctrl
  import ir_keymap_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int MAX_BUTTONS = 32,
  localparam int GIW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int SIW = (MAX_BUTTONS > 1) ? $clog2(MAX_BUTTONS) : 1,
  localparam int CNT_W = $clog2(MAX_BUTTONS + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               frame_valid,
  input  ucode_t                             frame_ucode,
  input  scan_t                              frame_scan,
  input  logic [NUM_GROUPS-1:0][UCODE_W-1:0] grp_ucode,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0]   grp_count,
  output logic [GIW-1:0]                     rd_grp,
  output logic [SIW-1:0]                     rd_slot,
  input  scan_t                              rd_scan,
  input  key_t                               rd_key,
  output logic                               busy,
  output logic                               ev_accept,
  output logic                               ev_hit,
  output logic                               ev_miss,
  output key_t                               fin_key,
  output ucode_t                             lat_ucode,
  output scan_t                              lat_scan
);

  srch_state_e      state;
  logic [GIW-1:0]   gidx;
  logic [CNT_W-1:0] bidx;

  logic grp_match;
  logic grp_last;
  logic btn_in_range;
  logic btn_match;

  assign grp_match    = f_group_match(grp_ucode[gidx], lat_ucode);
  assign grp_last     = (gidx == GIW'(NUM_GROUPS - 1));
  assign btn_in_range = (bidx < grp_count[gidx]);
  assign btn_match    = btn_in_range && (rd_scan == lat_scan);

  assign busy      = (state != SRCH_IDLE);
  assign ev_accept = (state == SRCH_IDLE) && frame_valid;
  assign ev_hit    = (state == SRCH_BTN) && btn_match;
  assign ev_miss   = ((state == SRCH_GRP) && !grp_match && grp_last) ||
                     ((state == SRCH_BTN) && !btn_in_range);
  assign fin_key   = rd_key;

  assign rd_grp  = gidx;
  assign rd_slot = bidx[SIW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SRCH_IDLE;
      gidx      <= '0;
      bidx      <= '0;
      lat_ucode <= '0;
      lat_scan  <= '0;
    end else begin
      unique case (state)
        SRCH_IDLE: begin
          if (frame_valid) begin
            lat_ucode <= frame_ucode;
            lat_scan  <= frame_scan;
            gidx      <= '0;
            bidx      <= '0;
            state     <= SRCH_GRP;
          end
        end
        SRCH_GRP: begin
          if (grp_match) begin
            bidx  <= '0;
            state <= SRCH_BTN;
          end else if (grp_last) begin
            state <= SRCH_IDLE;
          end else begin
            gidx <= gidx + GIW'(1);
          end
        end
        SRCH_BTN: begin
          if (!btn_in_range || btn_match) begin
            state <= SRCH_IDLE;
          end else begin
            bidx <= bidx + CNT_W'(1);
          end
        end
        default: state <= SRCH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ikm_result_reg.sv
module ikm_result_reg
  import ir_keymap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_hit,
  input  logic ev_miss,
  input  key_t fin_key,
  output key_t key_code,
  output rpt_t key_repeat,
  output logic hit,
  output logic miss,
  output logic done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_code   <= KEY_NONE;
      key_repeat <= '0;
      hit        <= 1'b0;
      miss       <= 1'b0;
      done       <= 1'b0;
    end else if (ev_hit) begin
      key_code   <= fin_key;
      key_repeat <= f_next_repeat(key_code, fin_key, key_repeat);
      hit        <= 1'b1;
      miss       <= 1'b0;
      done       <= 1'b1;
    end else if (ev_miss) begin
      key_code   <= KEY_NONE;
      key_repeat <= '0;
      hit        <= 1'b0;
      miss       <= 1'b1;
      done       <= 1'b1;
    end else begin
      done       <= 1'b0;
    end
  end

endmodule

// File: rtl/ir_keymap_lookup.sv
module ir_keymap_lookup
  import ir_keymap_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int MAX_BUTTONS = 32,
  localparam int GIW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int SIW = (MAX_BUTTONS > 1) ? $clog2(MAX_BUTTONS) : 1,
  localparam int CNT_W = $clog2(MAX_BUTTONS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  logic [15:0]        frame_ucode,
  input  logic [7:0]         frame_scan,
  input  logic               grp_wr_en,
  input  logic [GIW-1:0]     grp_wr_idx,
  input  logic [15:0]        grp_wr_ucode,
  input  logic [CNT_W-1:0]   grp_wr_count,
  input  logic               btn_wr_en,
  input  logic [GIW-1:0]     btn_wr_grp,
  input  logic [SIW-1:0]     btn_wr_slot,
  input  logic [7:0]         btn_wr_scan,
  input  logic [7:0]         btn_wr_key,
  output logic               busy,
  output logic               done,
  output logic [7:0]         key_code,
  output logic [7:0]         key_repeat,
  output logic               hit,
  output logic               miss
);

  logic [NUM_GROUPS-1:0][UCODE_W-1:0] grp_ucode;
  logic [NUM_GROUPS-1:0][CNT_W-1:0]   grp_count;
  logic [GIW-1:0] rd_grp;
  logic [SIW-1:0] rd_slot;
  scan_t          rd_scan;
  key_t           rd_key;

  // Named internal events, observed by the bound checker.
  logic   ev_accept;
  logic   ev_hit;
  logic   ev_miss;
  key_t   fin_key;
  ucode_t lat_ucode;
  scan_t  lat_scan;

  ikm_group_regs #(
    .NUM_GROUPS (NUM_GROUPS),
    .MAX_BUTTONS(MAX_BUTTONS)
  ) u_groups (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (grp_wr_en),
    .wr_idx   (grp_wr_idx),
    .wr_ucode (grp_wr_ucode),
    .wr_count (grp_wr_count),
    .grp_ucode(grp_ucode),
    .grp_count(grp_count)
  );

  ikm_button_store #(
    .NUM_GROUPS (NUM_GROUPS),
    .MAX_BUTTONS(MAX_BUTTONS)
  ) u_buttons (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (btn_wr_en),
    .wr_grp (btn_wr_grp),
    .wr_slot(btn_wr_slot),
    .wr_scan(btn_wr_scan),
    .wr_key (btn_wr_key),
    .rd_grp (rd_grp),
    .rd_slot(rd_slot),
    .rd_scan(rd_scan),
    .rd_key (rd_key)
  );

  ikm_search_ctrl #(
    .NUM_GROUPS (NUM_GROUPS),
    .MAX_BUTTONS(MAX_BUTTONS)
  ) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_valid(frame_valid),
    .frame_ucode(frame_ucode),
    .frame_scan (frame_scan),
    .grp_ucode  (grp_ucode),
    .grp_count  (grp_count),
    .rd_grp     (rd_grp),
    .rd_slot    (rd_slot),
    .rd_scan    (rd_scan),
    .rd_key     (rd_key),
    .busy       (busy),
    .ev_accept  (ev_accept),
    .ev_hit     (ev_hit),
    .ev_miss    (ev_miss),
    .fin_key    (fin_key),
    .lat_ucode  (lat_ucode),
    .lat_scan   (lat_scan)
  );

  ikm_result_reg u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_hit    (ev_hit),
    .ev_miss   (ev_miss),
    .fin_key   (fin_key),
    .key_code  (key_code),
    .key_repeat(key_repeat),
    .hit       (hit),
    .miss      (miss),
    .done      (done)
  );

endmodule

// File: rtl/ir_keymap_lookup_checker.sv
module ir_keymap_lookup_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_valid,
  input logic        busy,
  input logic        done,
  input logic [7:0]  key_code,
  input logic [7:0]  key_repeat,
  input logic        hit,
  input logic        miss,
  input logic        ev_accept,
  input logic        ev_hit,
  input logic        ev_miss,
  input logic [7:0]  fin_key,
  input logic [15:0] lat_ucode,
  input logic [7:0]  lat_scan
);

  // R12: the result strobe never lasts two cycles
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: once results are valid the search has finished
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: an accepted frame starts a search
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  // R6: a miss shows the no-key value and a cleared count
  a_r6_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && miss) |-> (key_code == 8'd0) && (key_repeat == 8'd0));

  // R5: each result is either a hit or a miss
  a_r5_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hit != miss));

  // R12: outputs hold between results
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_hit || ev_miss) |=> $stable(key_code) && $stable(key_repeat) &&
                             $stable(hit) && $stable(miss));

  // R10: a strobe during a search leaves the latched codes alone
  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_valid) |=> $stable(lat_ucode) && $stable(lat_scan));

  // R7: a repeated key code advances the count
  a_r7_repeat_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && (fin_key == key_code) && (key_repeat != 8'hFF))
      |=> (key_repeat == $past(key_repeat) + 8'd1));

  // R7: a different key code restarts the count
  a_r7_repeat_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && (fin_key != key_code)) |=> (key_repeat == 8'd0));

  // R8: saturation at the top value
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && (fin_key == key_code) && (key_repeat == 8'hFF))
      |=> (key_repeat == 8'hFF));

  // R12: hit and miss events never coincide
  a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_hit && ev_miss));

endmodule

bind ir_keymap_lookup ir_keymap_lookup_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_valid(frame_valid),
  .busy       (busy),
  .done       (done),
  .key_code   (key_code),
  .key_repeat (key_repeat),
  .hit        (hit),
  .miss       (miss),
  .ev_accept  (ev_accept),
  .ev_hit     (ev_hit),
  .ev_miss    (ev_miss),
  .fin_key    (fin_key),
  .lat_ucode  (lat_ucode),
  .lat_scan   (lat_scan)
);

// File: tb/test_ir_keymap_lookup.sv
`timescale 1ns/1ps
module test_ir_keymap_lookup;

  localparam int NG = 4;
  localparam int MB = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [15:0] frame_ucode = '0;
  logic [7:0]  frame_scan = '0;
  logic        grp_wr_en = 1'b0;
  logic [1:0]  grp_wr_idx = '0;
  logic [15:0] grp_wr_ucode = '0;
  logic [5:0]  grp_wr_count = '0;
  logic        btn_wr_en = 1'b0;
  logic [1:0]  btn_wr_grp = '0;
  logic [4:0]  btn_wr_slot = '0;
  logic [7:0]  btn_wr_scan = '0;
  logic [7:0]  btn_wr_key = '0;
  logic        busy, done, hit, miss;
  logic [7:0]  key_code, key_repeat;

  always #4 clk = ~clk;

  ir_keymap_lookup i_ir_keymap_lookup (
    .clk(clk), .rst_n(rst_n),
    .frame_valid(frame_valid), .frame_ucode(frame_ucode), .frame_scan(frame_scan),
    .grp_wr_en(grp_wr_en), .grp_wr_idx(grp_wr_idx), .grp_wr_ucode(grp_wr_ucode),
    .grp_wr_count(grp_wr_count),
    .btn_wr_en(btn_wr_en), .btn_wr_grp(btn_wr_grp), .btn_wr_slot(btn_wr_slot),
    .btn_wr_scan(btn_wr_scan), .btn_wr_key(btn_wr_key),
    .busy(busy), .done(done), .key_code(key_code), .key_repeat(key_repeat),
    .hit(hit), .miss(miss)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0] key;
    logic [7:0] rpt;
    logic       hit;
    int         lat;
    int         t0;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // Bench-side table model
  logic [15:0] m_uc [NG];
  int          m_n  [NG];
  logic [7:0]  m_sc [NG][MB];
  logic [7:0]  m_kc [NG][MB];
  logic [7:0]  m_key = 8'd0;
  logic [7:0]  m_rpt = 8'd0;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wr_group(int g, logic [15:0] uc, int n);
    @(negedge clk);
    grp_wr_en = 1'b1; grp_wr_idx = 2'(g); grp_wr_ucode = uc; grp_wr_count = 6'(n);
    @(negedge clk);
    grp_wr_en = 1'b0;
    if (uc != 16'd0) begin          // R2: zero user code is dropped
      m_uc[g] = uc;
      m_n[g]  = (n > MB) ? MB : n;  // R4: clamp
    end
  endtask

  task automatic wr_button(int g, int s, logic [7:0] sc, logic [7:0] kc);
    @(negedge clk);
    btn_wr_en = 1'b1; btn_wr_grp = 2'(g); btn_wr_slot = 5'(s);
    btn_wr_scan = sc; btn_wr_key = kc;
    @(negedge clk);
    btn_wr_en = 1'b0;
    m_sc[g][s] = sc;
    m_kc[g][s] = kc;
  endtask

  // Expected outcome restated from the requirements
  task automatic predict(logic [15:0] uc, logic [7:0] sc, string tag, int t0);
    exp_t e;
    bit found_g = 0;
    bit found_s = 0;
    e.lat = NG;
    e.key = 8'd0;
    for (int g = 0; g < NG && !found_g; g++) begin
      if (m_uc[g] != 16'd0 && m_uc[g] == uc) begin
        found_g = 1;
        e.lat = g + m_n[g] + 2;
        for (int s = 0; s < m_n[g] && !found_s; s++) begin
          if (m_sc[g][s] == sc) begin
            found_s = 1;
            e.key = m_kc[g][s];
            e.lat = g + s + 2;
          end
        end
      end
    end
    if (found_s) begin
      m_rpt = (e.key != m_key) ? 8'd0 : ((m_rpt == 8'hFF) ? 8'hFF : m_rpt + 8'd1);
      m_key = e.key;
    end else begin
      m_rpt = 8'd0;
      m_key = 8'd0;
    end
    e.rpt = m_rpt;
    e.hit = found_s;
    e.t0  = t0;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Driver: one frame, wait for its result
  task automatic send(logic [15:0] uc, logic [7:0] sc, string tag, bit inject = 0);
    int t0;
    @(negedge clk);
    frame_valid = 1'b1; frame_ucode = uc; frame_scan = sc;
    t0 = cyc;
    predict(uc, sc, tag, t0);
    @(negedge clk);
    frame_valid = 1'b0;
    if (inject) begin
      // R10: strobe during the running search
      check("R10", "busy during search", int'(busy), 1);
      frame_valid = 1'b1; frame_ucode = 16'h10EF; frame_scan = 8'h01;
      @(negedge clk);
      frame_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pop and compare each result
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check("R10", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "key_code", int'(key_code), int'(e.key));
        check(e.tag, "key_repeat", int'(key_repeat), int'(e.rpt));
        check(e.tag, "hit", int'(hit), int'(e.hit));
        check(e.tag, "miss", int'(miss), int'(!e.hit));
        check("R9", "latency", cyc - e.t0 - 1, e.lat);
        check("R9", "busy low at done", int'(busy), 0);
      end
    end
  end

  // R12: done is a single-cycle pulse
  logic done_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done && done_q) check("R12", "done width", 2, 1);
    done_q <= done;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_uc[g] = 16'd0;
      m_n[g]  = 0;
      for (int s = 0; s < MB; s++) begin
        m_sc[g][s] = 8'd0;
        m_kc[g][s] = 8'd0;
      end
    end
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "key_code", int'(key_code), 0);
    check("R1", "key_repeat", int'(key_repeat), 0);
    check("R1", "hit", int'(hit), 0);
    check("R1", "miss", int'(miss), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "busy", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11: empty table and zero user code both miss
    send(16'h0000, 8'h00, "R11");
    send(16'h10EF, 8'h01, "R1");

    // Load the table
    wr_group(0, 16'h10EF, 3);
    wr_button(0, 0, 8'h01, 8'h11);
    wr_button(0, 1, 8'h02, 8'h12);
    wr_button(0, 2, 8'h03, 8'h13);
    wr_button(0, 3, 8'h04, 8'h14);   // stale slot beyond the count
    wr_group(1, 16'h20DF, 0);
    wr_group(2, 16'h10EF, 2);        // shadowed duplicate
    wr_button(2, 0, 8'h05, 8'h25);
    wr_group(3, 16'h4BB4, 40);       // clamps to 32
    for (int s = 0; s < MB; s++) wr_button(3, s, 8'(8'h80 + s), 8'(8'h40 + s));
    wr_group(0, 16'h0000, 1);        // R2: dropped

    send(16'h10EF, 8'h02, "R5");
    send(16'h10EF, 8'h02, "R7");
    send(16'h10EF, 8'h02, "R7");
    send(16'h10EF, 8'h01, "R7");
    send(16'h10EF, 8'h03, "R2");     // count 3 survived the dropped write
    send(16'h10EF, 8'h04, "R4");     // beyond count
    send(16'h10EF, 8'h05, "R3");     // only in shadowed group
    send(16'h20DF, 8'h01, "R6");     // empty group
    send(16'h7777, 8'h01, "R6");     // unknown remote
    send(16'h4BB4, 8'h9F, "R4");     // last clamped slot
    send(16'h4BB4, 8'h85, "R10", 1);
    send(16'h0000, 8'h80, "R11");

    // R8: run past saturation, then break with a miss
    for (int i = 0; i < 260; i++) send(16'h4BB4, 8'h81, "R8");
    send(16'h7777, 8'h81, "R6");
    send(16'h4BB4, 8'h81, "R7");

    repeat (5) @(negedge clk);
    check("R10", "leftover expectations", sb.size(), 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule